// File: doc/BRIEF.md
# PHY Management Serial Master

This block gives software access to the registers of external Ethernet PHYs over the two-wire management bus. A management clock (MDC) and a bidirectional data line (MDIO) are used. Software works through three 16-bit registers. It loads the value to be written into a data-out register. It then writes a command word that holds the target PHY address, the register number and one start bit, which selects a write or a read. The block shifts a standard clause-22 frame onto the bus. It samples the PHY's reply when the command is a read. When the frame is done, it clears the start bit.

The start bits double as busy flags. Software polls the command register until the bit it set reads back as zero. It then collects read results from a separate read-result register. MDC is made from the system clock by a parameterized divider and stays low whenever no frame is running. A command written while a transaction is in flight is dropped. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads 0 and the outputs are as follows: MDC is low, the MDIO output enable is low and the MDIO output is low.
- R2: Register selects are 0 for command, 1 for write data and 2 for read result; select 3 reads 0. In the command word, PHY address is bits 12:8, register number is bits 4:0, bit 14 starts a write and bit 13 starts a read. When both start bits are set, the command is a write. A command word with neither start bit set is ignored.
- R3: The start bit of an accepted command reads back as 1 on the first poll after the write. It clears by itself when the frame is finished. A transaction takes fewer than 2048 single-cycle polls.
- R4: A write frame on the line, MSB first, is 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then turnaround 10, then the 16 data bits.
- R5: A read frame uses opcode 10. The master releases MDIO (output enable low) for the turnaround and the 16 data bits, and never drives while the PHY drives. It samples the data on rising MDC edges into the read-result register. That register changes only when a read completes.
- R6: The data sent by a write is the write-data register's value at the time the command is accepted. That register reads back what was written.
- R7: MDC has a period of 2*DIV_HALF system clocks while a frame runs and is low while no command is busy.
- R8: A command written while a transaction is busy is ignored. The stored address fields and the kind of operation are unchanged, and no second frame appears.
- R9: While the master drives MDIO, the MDIO output changes only on falling edges of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The following are checked on every cycle:
- the two busy flags are never set together;
- MDC stays low while idle;
- the output enable is raised only inside a running frame;
- driven MDIO changes only on falling MDC edges;
- busy-time command writes leave the stored fields unchanged;
- the read-result register stays stable between completions.

A PHY model in the bench decodes each frame bit by bit, answers reads and stores writes. Only these scenarios can show the exact frame contents, the round trip of read data, the MDC period, the poll count per transaction and the absence of a second frame after a dropped command.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  // command word bit positions (software visible)
  localparam int unsigned CMD_WR_BIT = 14;
  localparam int unsigned CMD_RD_BIT = 13;
  localparam int unsigned PHY_LSB    = 8;
  localparam int unsigned REGN_LSB   = 0;

  typedef enum logic [1:0] {
    RA_CMD   = 2'd0,
    RA_WDATA = 2'd1,
    RA_RDATA = 2'd2,
    RA_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i && wrap && !mdc_q;
  assign fall_o = run_i && wrap &&  mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mdio_op_e          op_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] regn_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned HDR_BITS   = 4 + 2 * ADDR_W;
  localparam int unsigned TA_BITS    = 2;
  localparam int unsigned FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_BITS + HDR_BITS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + HDR_BITS + TA_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  run_q, run_d;
  mdio_op_e              op_q, op_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] shr_q, shr_d;
  logic [DATA_W-1:0]     cap_q, cap_d;
  logic                  done_q, done_d;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    if (op_i == OP_WRITE)
      frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phy_i, regn_i, 2'b10, wdata_i};
    else
      frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy_i, regn_i, 2'b11, {DATA_W{1'b1}}};
  end

  always_comb begin
    run_d  = run_q;
    op_d   = op_q;
    idx_d  = idx_q;
    shr_d  = shr_q;
    cap_d  = cap_q;
    done_d = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        op_d  = op_i;
        idx_d = '0;
        shr_d = frame;
        cap_d = '0;
      end
    end else begin
      if (rise_i && (op_q == OP_READ) && (idx_q >= DATA_IDX))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          shr_d = {shr_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      op_q   <= OP_WRITE;
      idx_q  <= '0;
      shr_q  <= '0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
      shr_q  <= shr_d;
      cap_q  <= cap_d;
      done_q <= done_d;
    end
  end

  assign run_o     = run_q;
  assign done_o    = done_q;
  assign rdata_o   = cap_q;
  assign mdio_o    = run_q && shr_q[FRAME_BITS-1];
  assign mdio_oe_o = run_q && ((op_q == OP_WRITE) || (idx_q < REL_IDX));
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              done_i,
  input  logic [DATA_W-1:0] seq_rdata_i,
  output logic              start_o,
  output mdio_op_e          op_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] regn_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_flag_o,
  output logic              rd_flag_o,
  output logic [ADDR_W-1:0] phy_q_o,
  output logic [ADDR_W-1:0] regn_q_o,
  output logic [DATA_W-1:0] rdata_q_o
);
  logic              wr_q, wr_d, rd_q, rd_d;
  logic [ADDR_W-1:0] phy_q, phy_d, regn_q, regn_d;
  logic [DATA_W-1:0] wdat_q, wdat_d, rdat_q, rdat_d;
  logic              busy, cmd_hit, want_wr, want_rd;

  assign busy    = wr_q || rd_q;
  assign cmd_hit = reg_we && (reg_sel_e'(reg_addr) == RA_CMD);
  assign want_wr = reg_wdata[CMD_WR_BIT];
  assign want_rd = reg_wdata[CMD_RD_BIT];
  assign start_o = cmd_hit && !busy && (want_wr || want_rd);
  assign op_o    = want_wr ? OP_WRITE : OP_READ;
  assign phy_o   = reg_wdata[PHY_LSB +: ADDR_W];
  assign regn_o  = reg_wdata[REGN_LSB +: ADDR_W];
  assign wdata_o = wdat_q;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    phy_d  = phy_q;
    regn_d = regn_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (start_o) begin
      wr_d   = want_wr;
      rd_d   = !want_wr;
      phy_d  = phy_o;
      regn_d = regn_o;
    end
    if (done_i) begin
      wr_d = 1'b0;
      rd_d = 1'b0;
      if (rd_q) rdat_d = seq_rdata_i;
    end
    if (reg_we && (reg_sel_e'(reg_addr) == RA_WDATA))
      wdat_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      phy_q  <= '0;
      regn_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      phy_q  <= phy_d;
      regn_q <= regn_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      RA_CMD: begin
        reg_rdata[CMD_WR_BIT]             = wr_q;
        reg_rdata[CMD_RD_BIT]             = rd_q;
        reg_rdata[PHY_LSB +: ADDR_W]      = phy_q;
        reg_rdata[REGN_LSB +: ADDR_W]     = regn_q;
      end
      RA_WDATA: reg_rdata = wdat_q;
      RA_RDATA: reg_rdata = rdat_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign wr_flag_o = wr_q;
  assign rd_flag_o = rd_q;
  assign phy_q_o   = phy_q;
  assign regn_q_o  = regn_q;
  assign rdata_q_o = rdat_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV_HALF = 4,
  parameter int unsigned PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              rst_sync_n;
  logic              start, seq_run, seq_done, tick_rise, tick_fall;
  mdio_op_e          start_op;
  logic [ADDR_W-1:0] start_phy, start_regn, phy_view, regn_view;
  logic [DATA_W-1:0] wdata_view, seq_rdata, rdata_view;
  logic              wr_flag, rd_flag;

  mdio_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mdio_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .done_i      (seq_done),
    .seq_rdata_i (seq_rdata),
    .start_o     (start),
    .op_o        (start_op),
    .phy_o       (start_phy),
    .regn_o      (start_regn),
    .wdata_o     (wdata_view),
    .wr_flag_o   (wr_flag),
    .rd_flag_o   (rd_flag),
    .phy_q_o     (phy_view),
    .regn_q_o    (regn_view),
    .rdata_q_o   (rdata_view)
  );

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (seq_run),
    .mdc_o  (mdc),
    .rise_o (tick_rise),
    .fall_o (tick_fall)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start),
    .op_i      (start_op),
    .phy_i     (start_phy),
    .regn_i    (start_regn),
    .wdata_i   (wdata_view),
    .rise_i    (tick_rise),
    .fall_i    (tick_fall),
    .mdio_i    (mdio_i),
    .run_o     (seq_run),
    .done_o    (seq_done),
    .rdata_o   (seq_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        wr_flag,
  input logic        rd_flag,
  input logic        seq_run,
  input logic        seq_done,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [4:0]  phy_view,
  input logic [4:0]  regn_view,
  input logic [15:0] rdata_view
);
  AST_ONE_OP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_flag && rd_flag)); // R2

  AST_RUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_run |-> (wr_flag || rd_flag)); // R3

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_flag || rd_flag) |-> !mdc); // R7

  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> seq_run); // R5

  AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(rdata_view)); // R5

  AST_BUSY_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_flag || rd_flag) && !seq_done && reg_we && reg_addr == 2'd0)
      |=> ($stable(phy_view) && $stable(regn_view) && $stable(wr_flag) && $stable(rd_flag))); // R8

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc)); // R9
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .wr_flag    (wr_flag),
  .rd_flag    (rd_flag),
  .seq_run    (seq_run),
  .seq_done   (seq_done),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .phy_view   (phy_view),
  .regn_view  (regn_view),
  .rdata_view (rdata_view)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int DIV_HALF = 4;
  localparam realtime TCLK = 10ns;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read, 2 both start bits
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 5'd1,  5'd4,  16'h01E1, 16'h0000},
    '{2'd1, 5'd1,  5'd4,  16'h0000, 16'h01E1},
    '{2'd0, 5'd31, 5'd31, 16'hA5C3, 16'h0000},
    '{2'd1, 5'd31, 5'd31, 16'h0000, 16'hA5C3},
    '{2'd1, 5'd0,  5'd2,  16'h0000, 16'h6634},
    '{2'd2, 5'd3,  5'd17, 16'h4000, 16'h0000},
    '{2'd1, 5'd3,  5'd17, 16'h0000, 16'h4000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;

  int tests = 0;
  int fails = 0;

  // PHY model state
  int          phy_cnt = 0;
  logic [63:0] phy_hist = '0;
  logic        phy_is_rd = 1'b0;
  logic [15:0] phy_word = '0;
  logic        phy_drv_en = 1'b0;
  logic        phy_drv_val = 1'b1;
  int          frames_seen = 0;
  logic [63:0] last_frame = '0;
  int          conflicts = 0;
  realtime     t_rise_prev = 0, t_rise_last = 0;
  bit [15:0]   phy_mem [1024];
  bit          phy_valid [1024];

  always #(TCLK/2) clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv_en ? phy_drv_val : 1'b1);

  mdio_mgmt_master #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_line)
  );

  function automatic logic [15:0] init_val(input int idx);
    logic [15:0] p;
    p = 16'(idx) * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  // PHY receive side: oe rising with MDC low marks a new frame
  always @(posedge mdc or posedge mdio_oe) begin
    if (!mdc) begin
      phy_cnt   = 0;
      phy_is_rd = 1'b0;
    end else begin
      if (mdio_oe && phy_drv_en) conflicts++;
      t_rise_prev = t_rise_last;
      t_rise_last = $realtime;
      phy_hist = {phy_hist[62:0], mdio_line};
      phy_cnt++;
      if (phy_cnt == 36) phy_is_rd = (phy_hist[1:0] == 2'b10);
      if (phy_cnt == 46 && phy_is_rd)
        phy_word = phy_valid[phy_hist[9:0]] ? phy_mem[phy_hist[9:0]] : init_val(int'(phy_hist[9:0]));
      if (phy_cnt == 64) begin
        frames_seen++;
        last_frame = phy_hist;
        if (phy_hist[29:28] == 2'b01) begin
          phy_mem[phy_hist[27:18]]   = phy_hist[15:0];
          phy_valid[phy_hist[27:18]] = 1'b1;
        end
      end
    end
  end

  // PHY drive side
  always @(negedge mdc) begin
    if (phy_is_rd && phy_cnt >= 47 && phy_cnt <= 63) begin
      phy_drv_en  = 1'b1;
      phy_drv_val = (phy_cnt == 47) ? 1'b0 : phy_word[15 - (phy_cnt - 48)];
    end else begin
      phy_drv_en = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int polls, output logic [15:0] first);
    logic [15:0] v;
    polls = 0;
    first = '0;
    do begin
      reg_rd(2'd0, v);
      if (polls == 0) first = v;
      polls++;
    end while ((v[14] || v[13]) && polls < 4000);
  endtask

  function automatic logic [15:0] cmd_word(input logic [1:0] kind, input logic [4:0] phy, input logic [4:0] regn);
    return {1'b0, kind != 2'd1, kind != 2'd0, phy, 3'b000, regn};
  endfunction

  initial begin
    #(200000 * TCLK);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, first;
    logic [63:0] ef;
    int polls, f0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    reg_rd(2'd0, v); check(v == 16'h0, "R1 cmd", v, 0);
    reg_rd(2'd1, v); check(v == 16'h0, "R1 wdata", v, 0);
    reg_rd(2'd2, v); check(v == 16'h0, "R1 rdata", v, 0);
    check(!mdc && !mdio_oe && !mdio_o, "R1 pins", {mdc, mdio_oe, mdio_o}, 0);

    // R2: command without start bits ignored; select 3 reads 0
    f0 = frames_seen;
    reg_wr(2'd0, 16'h0305);
    repeat (20) @(negedge clk);
    reg_rd(2'd0, v); check(v == 16'h0, "R2 no-start cmd", v, 0);
    check(frames_seen == f0, "R2 no frame", frames_seen, f0);
    reg_rd(2'd3, v); check(v == 16'h0, "R2 spare select", v, 0);

    // vector table
    foreach (VECS[i]) begin
      f0 = frames_seen;
      if (VECS[i].kind != 2'd1) begin
        reg_wr(2'd1, VECS[i].data);
        reg_rd(2'd1, v); check(v == VECS[i].data, "R6 wdata readback", v, VECS[i].data);
      end
      reg_wr(2'd0, cmd_word(VECS[i].kind, VECS[i].phy, VECS[i].regn));
      wait_idle(polls, first);
      check(first == {1'b0, VECS[i].kind != 2'd1, VECS[i].kind == 2'd1, VECS[i].phy, 3'b000, VECS[i].regn},
            "R3 busy readback", first, 0);
      check(polls > 1 && polls < 2048, "R3 poll count", polls, 2048);
      check(frames_seen == f0 + 1, "R4 one frame", frames_seen, f0 + 1);
      if (VECS[i].kind != 2'd1) begin
        ef = {32'hFFFFFFFF, 2'b01, 2'b01, VECS[i].phy, VECS[i].regn, 2'b10, VECS[i].data};
        check(last_frame == ef, "R4 write frame", last_frame, ef);
      end else begin
        ef = {32'hFFFFFFFF, 2'b01, 2'b10, VECS[i].phy, VECS[i].regn, 2'b10, VECS[i].exp};
        check(last_frame == ef, "R5 read frame", last_frame, ef);
        reg_rd(2'd2, v); check(v == VECS[i].exp, "R5 read result", v, VECS[i].exp);
      end
      check(!mdc && !mdio_oe, "R7 idle pins", {mdc, mdio_oe}, 0);
    end

    // R7: MDC period
    check((t_rise_last - t_rise_prev) == 2 * DIV_HALF * TCLK, "R7 mdc period",
          64'(int'((t_rise_last - t_rise_prev) / 1ns)), 64'(2 * DIV_HALF * 10));

    // R8: command while busy dropped; R5 rdata untouched by a write
    f0 = frames_seen;
    reg_wr(2'd1, 16'h1234);
    reg_wr(2'd0, cmd_word(2'd0, 5'd5, 5'd6));
    repeat (30) @(negedge clk);
    reg_wr(2'd0, cmd_word(2'd1, 5'd9, 5'd9));
    reg_rd(2'd0, v);
    check(v == cmd_word(2'd0, 5'd5, 5'd6) , "R8 fields kept", v, cmd_word(2'd0, 5'd5, 5'd6));
    wait_idle(polls, first);
    repeat (600) @(negedge clk);
    check(frames_seen == f0 + 1, "R8 single frame", frames_seen, f0 + 1);
    ef = {32'hFFFFFFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h1234};
    check(last_frame == ef, "R8 frame of first cmd", last_frame, ef);
    reg_rd(2'd2, v); check(v == 16'h4000, "R5 rdata kept after write", v, 16'h4000);

    // R6: wdata sampled at accept; later change does not alter the frame
    reg_wr(2'd1, 16'hBEEF);
    reg_wr(2'd0, cmd_word(2'd0, 5'd2, 5'd3));
    reg_wr(2'd1, 16'h0F0F);
    wait_idle(polls, first);
    ef = {32'hFFFFFFFF, 2'b01, 2'b01, 5'd2, 5'd3, 2'b10, 16'hBEEF};
    check(last_frame == ef, "R6 data at accept", last_frame, ef);

    check(conflicts == 0, "R5 no bus contention", conflicts, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule